// File: doc/BRIEF.md
# Serial ADC Output Frame Emulator

This block models the digital side of a small successive-approximation converter's serial port. A host drives an active-low chip select and a serial clock. The block answers on a serial data bit with a separate output-enable that stands for the high-impedance state. A parallel input carries the value that a real converter would have sampled from its analog pin. That value is captured when chip select falls and then sent as a 16-slot frame: two leading zeros, the result MSB first, and trailing zeros. After the sixteenth falling clock edge, or when chip select is released, the line returns to high impedance.

The block also reports the track-and-hold phase. Releasing chip select before the conversion clock count is complete ends the conversion early and raises an abort flag. In the 8-bit build the same early release also puts the part into power-down. That status stays set until a later frame runs through the full conversion count. The resolution (12, 10 or 8 bits) is a parameter.

Host signals are assumed to be synchronous to the system clock `clk`. Each output reacts one `clk` cycle after the host edge is seen.

Top module: `sadc_serial_port`

## Requirements
- R1: After reset, sdo_en is 0, sdo is 0, tracking is 1, aborted is 0 and power_down is 0.
- R2: One clk cycle after cs_n falls, sdo_en is 1, sdo is 0 (first leading zero) and tracking is 0 (hold). aborted clears at the same time.
- R3: Frame slot p (p = 0..15) is on sdo after the p-th serial-clock falling edge of the frame. Slots 0 and 1 are 0. Slot p for 2 <= p < RES_BITS+2 carries sample bit RES_BITS+1-p, so the MSB comes first.
- R4: Slots RES_BITS+2 to 15 are 0. On the 16th falling edge sdo_en drops to 0, and later falling edges in the same frame leave it at 0.
- R5: tracking returns to 1 on the first serial-clock rising edge after RES_BITS+1 falling edges. It stays 0 at every rising edge before that.
- R6: If cs_n rises after fewer than RES_BITS+2 falling edges, sdo_en goes to 0, aborted goes to 1 and tracking goes to 1.
- R7: In the 8-bit build, an early cs_n rise as in R6 also sets power_down. Builds with 10 or 12 bits never set power_down.
- R8: power_down stays 1 through frames that are released early. It clears on the RES_BITS+2-th falling edge of a later frame.
- R9: If cs_n rises after at least RES_BITS+2 falling edges (for example a 14-clock frame), sdo_en goes to 0 and aborted stays 0.
- R10: sample_in is captured on the cs_n falling edge. Changes to it during the frame do not alter the bits shifted out.
- R11: Serial-clock edges while cs_n is high are ignored: sdo_en stays 0, and the next frame starts again from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock, idles high |
| sample_in | input | RES_BITS | Value that stands in for the sampled analog input |
| sdo | output | 1 | Serial data bit, 0 while disabled |
| sdo_en | output | 1 | 1 while the data line is driven, 0 for high impedance |
| tracking | output | 1 | 1 while track-and-hold is tracking, 0 while holding |
| aborted | output | 1 | Last frame was released before the conversion finished |
| power_down | output | 1 | Power-down state (8-bit build only) |

## Verification
The hardest state to reach is power-down that has to persist. It needs an early release in the 8-bit build, then a second frame that is also too short to clear it, then a full frame that clears it exactly at the tenth falling edge. The bench runs one 12-bit and one 8-bit instance from the same chip select and serial clock. A 5-clock frame therefore aborts both, but only the 8-bit instance powers down. A 9-clock frame then checks that the state persists. A 16-clock frame checks that power_down is still set at the ninth falling edge and clear at the tenth. Sample changes in the middle of a frame, and clock edges while deselected, are brought about directly around those frames.

// File: rtl/sadc_pkg.sv
// Shared constants and helpers for the serial ADC frame emulator.
// Assumes a fixed 16-slot frame that starts with two leading zeros.
package sadc_pkg;
    localparam int FRAME_LEN  = 16;
    localparam int LEAD_ZEROS = 2;

    // Number of falling serial-clock edges one conversion needs.
    function automatic int conv_clocks(input int res_bits);
        return res_bits + LEAD_ZEROS;
    endfunction
endpackage

// File: rtl/sadc_edge_det.sv
// Edge detector for a vector of host signals that are synchronous to clk.
// One register stage per bit. The rise and fall outputs are combinational
// from the live input and the registered previous value.
module sadc_edge_det #(
    parameter int           N       = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Remember the previous level of each input.
        always_ff @(posedge clk) begin
            if (!rst_n) prev[i] <= RST_VAL[i];
            else        prev[i] <= din[i];
        end
        assign rise[i] = din[i] & ~prev[i];
        assign fall[i] = ~din[i] & prev[i];
    end
endmodule

// File: rtl/sadc_frame_ctrl.sv
// Frame sequencer: counts falling serial-clock edges within a frame and
// owns the drive enable, track-and-hold phase, abort flag and power-down.
// Assumes the sclk edges it receives are already qualified by chip select.
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_low,
    input  logic cs_fall,
    input  logic cs_rise,
    input  logic sclk_fall,
    input  logic sclk_rise,
    output logic load_en,
    output logic shift_en,
    output logic out_en,
    output logic tracking,
    output logic aborted,
    output logic power_down
);
    localparam int             CW      = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0]  CONV_N  = CW'(conv_clocks(RES_BITS));
    localparam logic [CW-1:0]  TRACK_N = CW'(conv_clocks(RES_BITS) - 1);
    localparam logic [CW-1:0]  LAST_N  = CW'(FRAME_LEN);
    localparam bit             PD_ON_ABORT = (RES_BITS == 8);

    logic [CW-1:0] fall_cnt;
    logic [CW-1:0] cnt_next;
    logic          active;
    logic          early_end;

    assign cnt_next  = fall_cnt + 1'b1;
    assign load_en   = cs_fall;
    assign shift_en  = sclk_fall & active;
    assign out_en    = active;
    assign early_end = cs_rise & active & (fall_cnt < CONV_N);

    // Edge count, frame activity, hold/track phase and abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_cnt <= '0;
            active   <= 1'b0;
            tracking <= 1'b1;
            aborted  <= 1'b0;
        end else if (cs_fall) begin
            fall_cnt <= '0;
            active   <= 1'b1;
            tracking <= 1'b0;
            aborted  <= 1'b0;
        end else if (cs_rise) begin
            active   <= 1'b0;
            tracking <= 1'b1;
            if (early_end) aborted <= 1'b1;
        end else begin
            if (shift_en) begin
                fall_cnt <= cnt_next;
                if (cnt_next == LAST_N) active <= 1'b0;
            end
            if (sclk_rise && cs_low && fall_cnt >= TRACK_N) tracking <= 1'b1;
        end
    end

    if (PD_ON_ABORT) begin : g_pd
        // Enter power-down on early release, leave after a full conversion.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   power_down <= 1'b0;
            else if (early_end)                           power_down <= 1'b1;
            else if (!cs_fall && shift_en && cnt_next == CONV_N) power_down <= 1'b0;
        end
    end else begin : g_no_pd
        assign power_down = 1'b0;
    end
endmodule

// File: rtl/sadc_shifter.sv
// Output frame register: loads lead zeros, the captured sample and trailing
// zeros on chip-select fall, then shifts left on each qualified sclk fall.
// The MSB of the register is the bit currently presented.
module sadc_shifter
    import sadc_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                shift_en,
    input  logic [RES_BITS-1:0] sample_in,
    output logic                bit_out
);
    localparam int TRAIL = FRAME_LEN - LEAD_ZEROS - RES_BITS;

    logic [FRAME_LEN-1:0] frame_q;

    // Capture the frame image or advance it by one slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_q <= '0;
        else if (load_en)  frame_q <= {{LEAD_ZEROS{1'b0}}, sample_in, {TRAIL{1'b0}}};
        else if (shift_en) frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
    end

    assign bit_out = frame_q[FRAME_LEN-1];
endmodule

// File: rtl/sadc_serial_port.sv
// Top of the serial ADC output frame emulator. Host chip select and serial
// clock must be synchronous to clk; each output follows one cycle after the
// host edge. RES_BITS selects 12, 10 or 8 bit resolution.
module sadc_serial_port #(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic [RES_BITS-1:0] sample_in,
    output logic                sdo,
    output logic                sdo_en,
    output logic                tracking,
    output logic                aborted,
    output logic                power_down
);
    logic [1:0] rise_v;
    logic [1:0] fall_v;
    logic       load_en;
    logic       shift_en;
    logic       out_en;
    logic       bit_out;

    sadc_edge_det #(.N(2), .RST_VAL(2'b11)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk}),
        .rise (rise_v),
        .fall (fall_v)
    );

    sadc_frame_ctrl #(.RES_BITS(RES_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (~cs_n),
        .cs_fall   (fall_v[1]),
        .cs_rise   (rise_v[1]),
        .sclk_fall (fall_v[0] & ~cs_n),
        .sclk_rise (rise_v[0] & ~cs_n),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .out_en    (out_en),
        .tracking  (tracking),
        .aborted   (aborted),
        .power_down(power_down)
    );

    sadc_shifter #(.RES_BITS(RES_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .sample_in(sample_in),
        .bit_out  (bit_out)
    );

    assign sdo_en = out_en;
    assign sdo    = out_en & bit_out;
endmodule

// File: rtl/sadc_serial_port_chk.sv
// Property checker for sadc_serial_port, attached with bind below.
// Observes only the top-level ports.
module sadc_serial_port_chk #(
    parameter int RES_BITS = 12
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic sdo_en,
    input logic tracking,
    input logic aborted,
    input logic power_down
);
    // R2
    cs_fall_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> (sdo_en && !sdo && !tracking && !aborted));

    // R6
    cs_high_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !sdo_en);

    // R4
    drive_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_en) |-> ($past($fell(sclk)) || $past($rose(cs_n))));

    // R5
    track_return_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tracking) |-> ($past($rose(sclk)) || $past($rose(cs_n))));

    // R7
    pd_entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_down) |-> ($past($rose(cs_n)) && aborted && RES_BITS == 8));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);
endmodule

bind sadc_serial_port sadc_serial_port_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo       (sdo),
    .sdo_en    (sdo_en),
    .tracking  (tracking),
    .aborted   (aborted),
    .power_down(power_down)
);

// File: tb/sadc_serial_port_test.sv
// Bench: a 12-bit instance and an 8-bit instance share chip select and
// serial clock. Table-driven frames first, then directed corner cases.
module sadc_serial_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic [11:0] s12 = '0;
    logic [7:0]  s8  = '0;
    logic sdo12, en12, trk12, ab12, pd12;
    logic sdo8,  en8,  trk8,  ab8,  pd8;
    int errors = 0;
    int checks = 0;
    bit pd8_exp = 1'b0;

    always #4 clk = ~clk;

    sadc_serial_port #(.RES_BITS(12)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(s12),
        .sdo(sdo12), .sdo_en(en12), .tracking(trk12), .aborted(ab12), .power_down(pd12));

    sadc_serial_port #(.RES_BITS(8)) uut_b (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample_in(s8),
        .sdo(sdo8), .sdo_en(en8), .tracking(trk8), .aborted(ab8), .power_down(pd8));

    // fields: [31:20] 12-bit sample, [19:12] 8-bit sample, [11:0] clocks
    localparam logic [31:0] VEC [6] = '{
        {12'hFFF, 8'hFF, 12'd16},
        {12'hA5A, 8'h5A, 12'd16},
        {12'h001, 8'h01, 12'd16},
        {12'h800, 8'h80, 12'd14},
        {12'h3C3, 8'hC3, 12'd16},
        {12'h000, 8'h00, 12'd16}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_bit(input int r, input int s, input int p);
        if (p < 2 || p >= r + 2) return 0;
        return (s >> (r + 1 - p)) & 1;
    endfunction

    // One frame of nclk serial clocks; cap12/cap8 are the values expected out.
    task automatic run_frame(input int cap12, input int cap8, input int nclk,
                             input bit change_mid);
        cs_n = 1'b0;
        wait_n(2);
        chk(en12 && !sdo12 && !trk12 && !ab12, "R2 res12 start", {en12, sdo12, trk12}, 3'b100);
        chk(en8 && !sdo8 && !trk8 && !ab8, "R2 res8 start", {en8, sdo8, trk8}, 3'b100);
        if (change_mid) begin
            s12 = ~s12;
            s8  = ~s8;
        end
        for (int k = 1; k <= nclk; k++) begin
            sclk = 1'b0;
            wait_n(2);
            if (k >= 16) begin
                chk(!en12, "R4 res12 drive off", en12, 0);
                chk(!en8, "R4 res8 drive off", en8, 0);
            end else begin
                chk(en12 && sdo12 == exp_bit(12, cap12, k),
                    (k < 14) ? "R3 res12 slot" : "R4 res12 trailing", sdo12, exp_bit(12, cap12, k));
                chk(en8 && sdo8 == exp_bit(8, cap8, k),
                    (k < 10) ? "R3 res8 slot" : "R4 res8 trailing", sdo8, exp_bit(8, cap8, k));
            end
            if (k == 10) pd8_exp = 1'b0;
            if (k == 9 || k == 10)
                chk(pd8 == pd8_exp, "R8 res8 pd at conversion end", pd8, pd8_exp);
            sclk = 1'b1;
            wait_n(2);
            chk(trk12 == (k >= 13), "R5 res12 track", trk12, k >= 13);
            chk(trk8 == (k >= 9), "R5 res8 track", trk8, k >= 9);
        end
        cs_n = 1'b1;
        wait_n(2);
        if (nclk < 10) pd8_exp = 1'b1;
        chk(!en12 && !en8, "R6 release drive off", {en12, en8}, 0);
        chk(ab12 == (nclk < 14), (nclk < 14) ? "R6 res12 abort" : "R9 res12 no abort", ab12, nclk < 14);
        chk(ab8 == (nclk < 10), (nclk < 10) ? "R6 res8 abort" : "R9 res8 no abort", ab8, nclk < 10);
        chk(trk12 && trk8, "R6 track after release", {trk12, trk8}, 3);
        chk(pd8 == pd8_exp, "R7 res8 power_down", pd8, pd8_exp);
        chk(!pd12, "R7 res12 never powers down", pd12, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        chk(!en12 && !sdo12 && trk12 && !ab12 && !pd12, "R1 res12 reset",
            {en12, sdo12, trk12, ab12, pd12}, 5'b00100);
        chk(!en8 && !sdo8 && trk8 && !ab8 && !pd8, "R1 res8 reset",
            {en8, sdo8, trk8, ab8, pd8}, 5'b00100);

        foreach (VEC[i]) begin
            s12 = VEC[i][31:20];
            s8  = VEC[i][19:12];
            run_frame(int'(VEC[i][31:20]), int'(VEC[i][19:12]), int'(VEC[i][11:0]), 1'b0);
            wait_n(2);
        end

        // R6 R7: early release aborts both, powers down only the 8-bit build
        s12 = 12'h5A5; s8 = 8'hA5;
        run_frame(12'h5A5, 8'hA5, 5, 1'b0);
        wait_n(2);
        // R8: a 9-clock frame is still too short, power-down persists
        run_frame(12'h5A5, 8'hA5, 9, 1'b0);
        wait_n(2);
        // R10: sample changes mid-frame; this full frame also clears power-down (R8)
        s12 = 12'hC35; s8 = 8'h3C;
        run_frame(12'hC35, 8'h3C, 16, 1'b1);
        chk(!pd8, "R8 res8 cleared after full frame", pd8, 0);
        wait_n(2);

        // R11: serial clock edges with chip select high are ignored
        for (int j = 0; j < 3; j++) begin
            sclk = 1'b0; wait_n(2);
            chk(!en12 && !en8 && !sdo12 && !sdo8, "R11 no drive while deselected",
                {en12, en8}, 0);
            sclk = 1'b1; wait_n(2);
        end
        s12 = 12'h9E7; s8 = 8'h6B;
        run_frame(12'h9E7, 8'h6B, 16, 1'b0);

        // R4: extra falling edges after slot 16 keep the line released
        cs_n = 1'b0; wait_n(2);
        for (int j = 0; j < 18; j++) begin
            sclk = 1'b0; wait_n(2);
            sclk = 1'b1; wait_n(2);
        end
        chk(!en12 && !en8, "R4 stays off after 18 clocks", {en12, en8}, 0);
        cs_n = 1'b1; wait_n(2);
        chk(!ab12 && !ab8, "R9 long frame not aborted", {ab12, ab8}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule